// File: doc/BRIEF.md
# Programming Voltage Ramp Controller

This block computes the digital target code, in millivolts, that an external programming-voltage amplifier follows. It tracks a smart-card session: when the session sequencer marks the session active, the code climbs from zero to a 5 V baseline. A write request then lifts it to one of three programming levels, and when the request is released the code returns to the baseline. A forced-zero command from the deactivation sequencer, or loss of the session-active flag, brings the code down to zero. Every movement happens at one controlled slew of 1000 mV per microsecond tick. The final step of any ramp is clamped onto its destination, so the code never overshoots.

A `settled` output tells the sequencer when the code has arrived at the level currently being aimed for. The tick comes from outside as a one-cycle pulse at 1 MHz, so the slew does not depend on the system clock frequency.

The controller is a seven-state machine. The states are OFF (held at zero), BOOT (climbing to baseline), IDLE (at baseline), RISE (climbing to the latched programming level), HOLD (at the programming level), FALL (returning to baseline) and DROP (descending to zero). The transitions are:
- OFF→BOOT when the session is active and forced-zero is clear.
- BOOT→IDLE when the baseline is reached.
- IDLE→RISE and FALL→RISE when a write is requested.
- RISE→HOLD when the programming level is reached.
- RISE→FALL and HOLD→FALL when the write is released.
- FALL→IDLE when the baseline is reached.
- Any state other than OFF goes to DROP when forced-zero is high or the session is inactive.
- DROP→OFF when zero is reached.

Top module: `vpp_ramp_ctrl`

## Requirements
- R1: After reset the code is 0 and `settled` is high.
- R2: The level select maps to these destinations: 00 gives 5000 mV, 01 gives 12500 mV, 10 gives 15000 mV and 11 gives 21000 mV.
- R3: The code changes only on a clock edge where `us_tick` is high, and by at most 1000 mV per tick. Without ticks it holds its value.
- R4: When the remaining distance is at most 1000 mV, the step lands exactly on the destination. The code never exceeds 21000 mV.
- R5: With the session active and forced-zero clear, the code climbs from 0 to 5000 mV at 1000 mV per tick.
- R6: A write request at baseline (IDLE or FALL) starts a climb to the selected level at 1000 mV per tick. The select is sampled only on the cycle the climb begins; later changes to it have no effect.
- R7: Releasing the write request, including partway through a climb, returns the code to 5000 mV at 1000 mV per tick.
- R8: Write requests have no effect while the session-active flag is low.
- R9: Forced-zero high or session-active low takes the code down to 0 at 1000 mV per tick. While that condition persists, the code never rises and stays at 0 once there.
- R10: `settled` is high exactly when the code equals the current destination. The destination is 0 while forced-zero is high or the session is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond that paces the slew |
| lvl_sel | input | 2 | Programming level select |
| write_req | input | 1 | Write mode request, active high |
| session_on | input | 1 | Session-active flag from the sequencer |
| force_zero | input | 1 | Deactivation command to collapse the code to 0 |
| vpp_mv | output | 15 | Programming voltage code in millivolts |
| settled | output | 1 | Code equals the current destination |

## Verification
A wrong state or a wrong latched level does not show as a single bad cycle. It shows as a code that stops one step short of its destination, runs past it, or moves in the wrong direction on the very next tick. The checks therefore read the code after each counted tick and compare it with the value the slew rule predicts. A state that fails to leave BOOT, RISE, FALL or DROP shows up as `settled` staying low, or as further movement after arrival, within one tick of the expected landing. A select that was resampled mid-climb shows as a wrong final level.

// File: rtl/vpp_ramp_pkg.sv
package vpp_ramp_pkg;

    typedef enum logic [2:0] {
        RS_OFF  = 3'd0,
        RS_BOOT = 3'd1,
        RS_IDLE = 3'd2,
        RS_RISE = 3'd3,
        RS_HOLD = 3'd4,
        RS_FALL = 3'd5,
        RS_DROP = 3'd6
    } ramp_state_e;

endpackage

// File: rtl/vpp_level_map.sv
module vpp_level_map #(
    parameter int CODE_W = 15,
    parameter int LVL0_MV = 5000,
    parameter int LVL1_MV = 12500,
    parameter int LVL2_MV = 15000,
    parameter int LVL3_MV = 21000
) (
    input  logic [1:0]        sel,
    output logic [CODE_W-1:0] level
);

    always_comb begin
        unique case (sel)
            2'b00: level = CODE_W'(LVL0_MV);
            2'b01: level = CODE_W'(LVL1_MV);
            2'b10: level = CODE_W'(LVL2_MV);
            default: level = CODE_W'(LVL3_MV);
        endcase
    end

endmodule

// File: rtl/vpp_slew_step.sv
module vpp_slew_step #(
    parameter int CODE_W = 15,
    parameter int STEP_MV = 1000
) (
    input  logic [CODE_W-1:0] cur,
    input  logic [CODE_W-1:0] tgt,
    input  logic              tick,
    output logic [CODE_W-1:0] nxt
);

    localparam logic [CODE_W-1:0] STEP_C = CODE_W'(STEP_MV);

    logic [CODE_W-1:0] gap_up;
    logic [CODE_W-1:0] gap_dn;

    assign gap_up = tgt - cur;
    assign gap_dn = cur - tgt;

    always_comb begin
        nxt = cur;
        if (tick) begin
            if (cur < tgt) begin
                nxt = (gap_up <= STEP_C) ? tgt : cur + STEP_C;
            end else if (cur > tgt) begin
                nxt = (gap_dn <= STEP_C) ? tgt : cur - STEP_C;
            end
        end
    end

endmodule

// File: rtl/vpp_ramp_fsm.sv
module vpp_ramp_fsm
    import vpp_ramp_pkg::*;
#(
    parameter int CODE_W = 15,
    parameter int BASE_MV = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kill,
    input  logic              write_req,
    input  logic [CODE_W-1:0] sel_level,
    input  logic [CODE_W-1:0] code_nxt,
    output ramp_state_e       state,
    output logic [CODE_W-1:0] target
);

    localparam logic [CODE_W-1:0] BASE_C = CODE_W'(BASE_MV);
    localparam logic [CODE_W-1:0] ZERO_C = '0;

    ramp_state_e       state_q, state_d;
    logic [CODE_W-1:0] level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= BASE_C;
        end else if (state_d == RS_RISE && state_q != RS_RISE) begin
            level_q <= sel_level;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_OFF: begin
                if (!kill) state_d = RS_BOOT;
            end
            RS_BOOT: begin
                if (kill) state_d = RS_DROP;
                else if (code_nxt == BASE_C) state_d = RS_IDLE;
            end
            RS_IDLE: begin
                if (kill) state_d = RS_DROP;
                else if (write_req) state_d = RS_RISE;
            end
            RS_RISE: begin
                if (kill) state_d = RS_DROP;
                else if (!write_req) state_d = RS_FALL;
                else if (code_nxt == level_q) state_d = RS_HOLD;
            end
            RS_HOLD: begin
                if (kill) state_d = RS_DROP;
                else if (!write_req) state_d = RS_FALL;
            end
            RS_FALL: begin
                if (kill) state_d = RS_DROP;
                else if (write_req) state_d = RS_RISE;
                else if (code_nxt == BASE_C) state_d = RS_IDLE;
            end
            RS_DROP: begin
                if (code_nxt == ZERO_C) state_d = RS_OFF;
            end
            default: state_d = RS_OFF;
        endcase
    end

    always_comb begin
        target = ZERO_C;
        if (!kill) begin
            unique case (state_q)
                RS_BOOT, RS_IDLE, RS_FALL: target = BASE_C;
                RS_RISE, RS_HOLD:          target = level_q;
                default:                   target = ZERO_C;
            endcase
        end
    end

    assign state = state_q;

endmodule

// File: rtl/vpp_ramp_ctrl.sv
module vpp_ramp_ctrl
    import vpp_ramp_pkg::*;
#(
    parameter int CODE_W = 15,
    parameter int STEP_MV = 1000,
    parameter int LVL0_MV = 5000,
    parameter int LVL1_MV = 12500,
    parameter int LVL2_MV = 15000,
    parameter int LVL3_MV = 21000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic [1:0]        lvl_sel,
    input  logic              write_req,
    input  logic              session_on,
    input  logic              force_zero,
    output logic [CODE_W-1:0] vpp_mv,
    output logic              settled
);

    logic              kill;
    logic [CODE_W-1:0] sel_level;
    logic [CODE_W-1:0] target;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] code_nxt;
    ramp_state_e       state;

    assign kill = force_zero || !session_on;

    vpp_level_map #(
        .CODE_W (CODE_W),
        .LVL0_MV(LVL0_MV),
        .LVL1_MV(LVL1_MV),
        .LVL2_MV(LVL2_MV),
        .LVL3_MV(LVL3_MV)
    ) u_map (
        .sel  (lvl_sel),
        .level(sel_level)
    );

    vpp_slew_step #(
        .CODE_W (CODE_W),
        .STEP_MV(STEP_MV)
    ) u_step (
        .cur (code_q),
        .tgt (target),
        .tick(us_tick),
        .nxt (code_nxt)
    );

    vpp_ramp_fsm #(
        .CODE_W (CODE_W),
        .BASE_MV(LVL0_MV)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .kill     (kill),
        .write_req(write_req),
        .sel_level(sel_level),
        .code_nxt (code_nxt),
        .state    (state),
        .target   (target)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else begin
            code_q <= code_nxt;
        end
    end

    assign vpp_mv  = code_q;
    assign settled = (code_q == target);

endmodule

// File: rtl/vpp_ramp_chk.sv
module vpp_ramp_chk #(
    parameter int CODE_W = 15,
    parameter int STEP_MV = 1000,
    parameter int LVL0_MV = 5000,
    parameter int LVL1_MV = 12500,
    parameter int LVL2_MV = 15000,
    parameter int LVL3_MV = 21000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              us_tick,
    input logic              session_on,
    input logic              force_zero,
    input logic [CODE_W-1:0] vpp_mv,
    input logic              settled
);

    // R3
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !us_tick |=> $stable(vpp_mv));

    // R3
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((vpp_mv >= $past(vpp_mv))
                  ? ((vpp_mv - $past(vpp_mv)) <= CODE_W'(STEP_MV))
                  : (($past(vpp_mv) - vpp_mv) <= CODE_W'(STEP_MV))));

    // R4
    no_overshoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_mv <= CODE_W'(LVL3_MV));

    // R9
    no_rise_when_killed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_zero || !session_on) |=> (vpp_mv <= $past(vpp_mv)));

    // R10
    settled_on_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        settled |-> (vpp_mv == '0 || vpp_mv == CODE_W'(LVL0_MV) ||
                     vpp_mv == CODE_W'(LVL1_MV) || vpp_mv == CODE_W'(LVL2_MV) ||
                     vpp_mv == CODE_W'(LVL3_MV)));

endmodule

bind vpp_ramp_ctrl vpp_ramp_chk #(
    .CODE_W (CODE_W),
    .STEP_MV(STEP_MV),
    .LVL0_MV(LVL0_MV),
    .LVL1_MV(LVL1_MV),
    .LVL2_MV(LVL2_MV),
    .LVL3_MV(LVL3_MV)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .us_tick   (us_tick),
    .session_on(session_on),
    .force_zero(force_zero),
    .vpp_mv    (vpp_mv),
    .settled   (settled)
);

// File: tb/tb_vpp_ramp_ctrl.sv
module tb_vpp_ramp_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b0;
    logic [1:0]  lvl_sel = 2'b00;
    logic        write_req = 1'b0;
    logic        session_on = 1'b0;
    logic        force_zero = 1'b0;
    logic [14:0] vpp_mv;
    logic        settled;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    vpp_ramp_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .us_tick   (us_tick),
        .lvl_sel   (lvl_sel),
        .write_req (write_req),
        .session_on(session_on),
        .force_zero(force_zero),
        .vpp_mv    (vpp_mv),
        .settled   (settled)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) us_tick = 1'b1;
            @(negedge clk) us_tick = 1'b0;
        end
    endtask

    task automatic t_reset;
        cyc(2);
        rst_n = 1'b1;
        cyc(2);
        chk("R1 code", vpp_mv, 0);
        chk("R1 settled", settled, 1);
    endtask

    task automatic t_boot;
        session_on = 1'b1;
        cyc(1);
        ticks(2);
        chk("R5 partial", vpp_mv, 2000);
        chk("R10 moving", settled, 0);
        ticks(3);
        chk("R5 baseline", vpp_mv, 5000);
        chk("R10 arrived", settled, 1);
    endtask

    task automatic t_rise_clamp;
        lvl_sel = 2'b01;
        write_req = 1'b1;
        cyc(1);
        lvl_sel = 2'b11;
        ticks(7);
        chk("R6 climb", vpp_mv, 12000);
        ticks(1);
        chk("R4 clamp 12500", vpp_mv, 12500);
        chk("R6 select latched", settled, 1);
        ticks(2);
        chk("R2 hold 12500", vpp_mv, 12500);
    endtask

    task automatic t_fall;
        write_req = 1'b0;
        cyc(1);
        ticks(7);
        chk("R7 falling", vpp_mv, 5500);
        ticks(1);
        chk("R4 clamp 5000", vpp_mv, 5000);
        chk("R7 settled", settled, 1);
    endtask

    task automatic t_top_level;
        lvl_sel = 2'b11;
        write_req = 1'b1;
        cyc(1);
        ticks(18);
        chk("R2 level 11", vpp_mv, 21000);
        write_req = 1'b0;
        cyc(1);
        ticks(16);
        chk("R7 back", vpp_mv, 5000);
    endtask

    task automatic t_sel_zero;
        lvl_sel = 2'b00;
        write_req = 1'b1;
        cyc(2);
        ticks(2);
        chk("R2 level 00", vpp_mv, 5000);
        chk("R2 level 00 settled", settled, 1);
        write_req = 1'b0;
        cyc(2);
    endtask

    task automatic t_no_tick;
        lvl_sel = 2'b10;
        write_req = 1'b1;
        cyc(12);
        chk("R3 no tick hold", vpp_mv, 5000);
        chk("R3 not settled", settled, 0);
        ticks(10);
        chk("R2 level 10", vpp_mv, 15000);
    endtask

    task automatic t_force_zero;
        force_zero = 1'b1;
        cyc(1);
        ticks(1);
        chk("R9 slew down", vpp_mv, 14000);
        ticks(14);
        chk("R9 zero", vpp_mv, 0);
        ticks(3);
        chk("R9 stays zero", vpp_mv, 0);
        chk("R10 zero settled", settled, 1);
        force_zero = 1'b0;
        write_req = 1'b0;
        cyc(1);
        ticks(5);
        chk("R5 reboot", vpp_mv, 5000);
    endtask

    task automatic t_reverse;
        lvl_sel = 2'b11;
        write_req = 1'b1;
        cyc(1);
        ticks(3);
        chk("R6 partial", vpp_mv, 8000);
        write_req = 1'b0;
        cyc(1);
        ticks(2);
        chk("R7 reversal", vpp_mv, 6000);
        ticks(1);
        chk("R7 reversal end", vpp_mv, 5000);
    endtask

    task automatic t_session_off;
        session_on = 1'b0;
        cyc(1);
        ticks(5);
        chk("R9 session drop", vpp_mv, 0);
        lvl_sel = 2'b11;
        write_req = 1'b1;
        cyc(1);
        ticks(4);
        chk("R8 write ignored", vpp_mv, 0);
        chk("R8 settled", settled, 1);
        write_req = 1'b0;
        cyc(1);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_boot();
        t_rise_clamp();
        t_fall();
        t_top_level();
        t_sel_zero();
        t_no_tick();
        t_force_zero();
        t_reverse();
        t_session_off();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

endmodule